// File: doc/BRIEF.md
# Coprocessor Handshake Responder

This block is the coprocessor-side half of the handshake that a host processor runs for every instruction in its decode stage. Each cycle it looks at a decoded-instruction valid flag and a match flag, which says that the instruction belongs to this coprocessor. It answers on two active-low response lines with one of three conditions: not mine, taken now, or busy-wait.

A busy-wait stalls the host until the coprocessor's engine reports ready. The block then releases the stall and issues a single-cycle start strobe to the engine. The host may drop the stalled instruction at any point during the wait, for example to take an interrupt. The block then cancels the pending instruction and issues no strobe. Nothing is committed before the strobe, so a cancelled wait leaves the engine's state untouched.

Reset is asserted asynchronously and released through a two-stage synchronizer. The response lines stay at "not mine" until the synchronized release has completed.

Top module: `cp_handshake_resp`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it goes high, both response lines are high and `start_exec` is low, whatever the other inputs do.
- R2: In idle, if `dec_valid` or `dec_match` is low, both `cpa_n` and `cpb_n` are high and `start_exec` is low.
- R3: In idle, if `dec_valid`, `dec_match` and `eng_ready` are all high, both lines go low and `start_exec` pulses in that same cycle. The block stays idle.
- R4: In idle, if a matched instruction arrives while `eng_ready` is low, the block drives `cpa_n` low and `cpb_n` high, and enters the wait state from the next cycle. It holds that response while neither `eng_ready` nor `host_abandon` is high. Decode inputs are ignored while it waits.
- R5: In the wait state, if `eng_ready` is high and `host_abandon` is low, `cpb_n` goes low with `cpa_n` low and `start_exec` pulses in that same cycle. The block is idle from the next cycle.
- R6: In the wait state, a high `host_abandon` cancels the instruction and takes priority over `eng_ready`. `start_exec` stays low in that cycle, and the block is idle and evaluates a fresh decode in the next cycle.
- R7: `start_exec` is high only in cycles where both response lines are low, and it pulses at most once per accepted instruction.
- R8: The line pair `cpa_n` high with `cpb_n` low is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_valid | input | 1 | Host decode stage holds a valid instruction |
| dec_match | input | 1 | Instruction in decode is addressed to this coprocessor |
| eng_ready | input | 1 | Coprocessor engine can start an instruction now |
| host_abandon | input | 1 | Host has dropped the stalled instruction |
| cpa_n | output | 1 | First active-low response line (low: instruction claimed) |
| cpb_n | output | 1 | Second active-low response line (low: go, stall released) |
| start_exec | output | 1 | One-cycle strobe that starts the engine on the instruction |

## Verification
Directed sequences cover four cases:
- A decode that is valid but not matched, which must read as absent.
- An immediate accept.
- A wait released by ready after several held cycles, with decode inputs toggling in between to show they are ignored.
- A wait ended by abandon, both alone and in the same cycle as ready, which separates the cancel priority from a release.

A seeded random run then mixes all four inputs, including back-to-back instructions and abandons in the first wait cycle. A bench reference model predicts the line pair and the strobe for every cycle, which tells a late or duplicated strobe apart from a wrongly held or wrongly released stall.

// File: rtl/cp_hs_pkg.sv
package cp_hs_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } cp_state_e;

  // bit 1 drives cpa_n, bit 0 drives cpb_n
  typedef enum logic [1:0] {
    RSP_ABSENT = 2'b11,
    RSP_GO     = 2'b00,
    RSP_BUSY   = 2'b01
  } cp_resp_e;

  localparam int unsigned RSP_A_BIT = 1;
  localparam int unsigned RSP_B_BIT = 0;
endpackage

// File: rtl/cp_rst_sync.sv
module cp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cp_wait_fsm.sv
module cp_wait_fsm
  import cp_hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     claim,
  input  logic     eng_ready,
  input  logic     host_abandon,
  output cp_resp_e resp,
  output logic     start_exec
);
  cp_state_e st_q;
  cp_state_e st_d;
  logic      st_en;

  always_comb begin
    st_d       = st_q;
    resp       = RSP_ABSENT;
    start_exec = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (claim) begin
          if (eng_ready) begin
            resp       = RSP_GO;
            start_exec = 1'b1;
          end else begin
            resp = RSP_BUSY;
            st_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (host_abandon) begin
          resp = RSP_BUSY;
          st_d = ST_IDLE;
        end else if (eng_ready) begin
          resp       = RSP_GO;
          start_exec = 1'b1;
          st_d       = ST_IDLE;
        end else begin
          resp = RSP_BUSY;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assert_absent_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !claim) |-> (resp == RSP_ABSENT && !start_exec));

  assert_go_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && claim && eng_ready) |=> (st_q == ST_IDLE));

  assert_hold_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !host_abandon && !eng_ready) |=> (st_q == ST_WAIT));

  assert_enter_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && claim && !eng_ready) |=> (st_q == ST_WAIT));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !host_abandon && eng_ready) |=> (st_q == ST_IDLE));

  assert_abandon_nostart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && host_abandon) |-> !start_exec);

  assert_abandon_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && host_abandon) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/cp_resp_encode.sv
module cp_resp_encode
  import cp_hs_pkg::*;
(
  input  cp_resp_e resp,
  output logic     cpa_n,
  output logic     cpb_n
);
  logic [1:0] resp_bits;

  assign resp_bits = resp;
  assign cpa_n     = resp_bits[RSP_A_BIT];
  assign cpb_n     = resp_bits[RSP_B_BIT];
endmodule

// File: rtl/cp_handshake_resp.sv
module cp_handshake_resp
  import cp_hs_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_valid,
  input  logic dec_match,
  input  logic eng_ready,
  input  logic host_abandon,
  output logic cpa_n,
  output logic cpb_n,
  output logic start_exec
);
  logic     rst_ok_n;
  logic     claim;
  cp_resp_e resp;

  cp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ok_n)
  );

  assign claim = rst_ok_n & dec_valid & dec_match;

  cp_wait_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_ok_n),
    .claim        (claim),
    .eng_ready    (eng_ready),
    .host_abandon (host_abandon),
    .resp         (resp),
    .start_exec   (start_exec)
  );

  cp_resp_encode u_enc (
    .resp  (resp),
    .cpa_n (cpa_n),
    .cpb_n (cpb_n)
  );

  assert_start_lines_low_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    start_exec |-> (!cpa_n && !cpb_n));

  assert_no_illegal_pair_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(cpa_n && !cpb_n));

  assert_reset_absent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok_n |-> (cpa_n && cpb_n && !start_exec));
endmodule

// File: tb/sim_cp_handshake_resp.sv
module sim_cp_handshake_resp;
  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, dec_match, eng_ready, host_abandon;
  logic cpa_n, cpb_n, start_exec;

  int n_checks = 0;
  int n_fail   = 0;
  logic m_wait = 1'b0;

  always #2 clk = ~clk;

  cp_handshake_resp u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_match(dec_match),
    .eng_ready(eng_ready), .host_abandon(host_abandon),
    .cpa_n(cpa_n), .cpb_n(cpb_n), .start_exec(start_exec)
  );

  // expected {cpa_n, cpb_n, start_exec, next_wait}
  function automatic logic [3:0] ref_step(input logic w, input logic v, input logic m,
                                          input logic r, input logic ab);
    logic cl;
    cl = v & m;
    if (!w) begin
      if (cl && r)  return 4'b0010;
      else if (cl)  return 4'b0101;
      else          return 4'b1100;
    end else begin
      if (ab)       return 4'b0100;
      else if (r)   return 4'b0010;
      else          return 4'b0101;
    end
  endfunction

  function automatic string ref_tag(input logic w, input logic v, input logic m,
                                    input logic r, input logic ab);
    if (!w) return (v && m) ? (r ? "R3" : "R4") : "R2";
    if (ab) return "R6";
    return r ? "R5" : "R4";
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {cpa_n,cpb_n,start}=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic m, input logic r, input logic ab);
    logic [3:0] e;
    string t;
    @(negedge clk);
    dec_valid = v; dec_match = m; eng_ready = r; host_abandon = ab;
    #1;
    e = ref_step(m_wait, v, m, r, ab);
    t = ref_tag(m_wait, v, m, r, ab);
    check(t, {cpa_n, cpb_n, start_exec}, e[3:1]);
    n_checks++;
    if (cpa_n === 1'b1 && cpb_n === 1'b0) begin
      n_fail++;
      $display("FAIL R8: lines=10 expected not 10");
    end
    n_checks++;
    if (start_exec === 1'b1 && (cpa_n !== 1'b0 || cpb_n !== 1'b0)) begin
      n_fail++;
      $display("FAIL R7: start with lines=%b%b expected 00", cpa_n, cpb_n);
    end
    m_wait = e[0];
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int starts;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    dec_valid = 1'b1; dec_match = 1'b1; eng_ready = 1'b1; host_abandon = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R1", {cpa_n, cpb_n, start_exec}, 3'b110);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1", {cpa_n, cpb_n, start_exec}, 3'b110);
    @(negedge clk);
    #1 check("R1", {cpa_n, cpb_n, start_exec}, 3'b110);
    m_wait = 1'b0;

    // R2: not matched / not valid
    step(1, 0, 1, 0);
    step(0, 1, 1, 0);
    step(0, 0, 0, 1);
    // R3: immediate accept, back to back
    step(1, 1, 1, 0);
    step(1, 1, 1, 0);
    // R4 then R5: wait held with decode toggling, then release
    step(1, 1, 0, 0);
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    // R6: abandon alone, then fresh accept next cycle
    step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    step(1, 1, 1, 0);
    // R6: abandon together with ready, no strobe
    step(1, 1, 0, 0);
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    // R6: abandon in first wait cycle followed by a new busy instruction
    step(1, 1, 0, 0);
    step(1, 1, 1, 1);
    step(1, 1, 0, 0);
    step(0, 0, 1, 0);

    // R7: strobe count equals accepted instructions over random run
    starts = 0;
    for (int i = 0; i < 3000; i++) begin
      logic v, m, r, ab;
      v  = ($urandom % 10) < 7;
      m  = ($urandom % 10) < 7;
      r  = ($urandom % 10) < 3;
      ab = ($urandom % 100) < 15;
      if (!m_wait && v && m && r) starts++;
      else if (m_wait && !ab && r) starts++;
      step(v, m, r, ab);
    end
    $display("accepted instructions in random run: %0d", starts);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule